// File: doc/BRIEF.md
# Buffered Synchronous Serial Channel

This block is a clocked serial port with SCK, SO and SI lines and an active-low chip-select input. It is paired with a 128-byte buffer RAM. Once started, the channel works through the buffer by itself. It fetches each outgoing byte, shifts it out most significant bit first, and stores the byte shifted in, until the programmed byte count is reached. No per-byte host service is needed.

The channel runs in one of two roles. As clock master it makes SCK from the block clock, holding each SCK level for `HALF` clocks. As slave it follows an external SCK. That SCK is synchronised, counted only while the chip select is low, and ignored for a short window after the chip select falls. In the normal layout, byte *i* is sent from buffer address *i* and the received byte overwrites it there. In the split layout, bytes are sent from the lower half and received into the upper half, and a transfer moves at most 64 bytes. A small register port sets the role, the layout and the length, starts the transfer, and gives the host direct access to the buffer.

The controller has three states. In IDLE it waits and accepts configuration; a start write moves it to XFER. In XFER it shifts bits; the last bit of the last byte moves it to TAIL. TAIL holds busy for a fixed number of clocks and then returns to IDLE.

Top module: `sio_chan`

## Requirements
- R1: After reset, busy and done are 0, SO and SCK are not driven (so_oe=0, sck_oe=0), and sck_o and so_o are both 1.
- R2: Host port: with host_sel=0, writes go to buffer byte host_addr and host_rdata returns that byte. With host_sel=1 the control word holds bit0 master, bit1 split and bit2 start (write only); on read, bit2 is busy and bit3 is done. With host_sel=2 the length field holds bytes-1 in bits 6:0. All host reads are combinational.
- R3: In master mode sck_oe=1, SCK idles high, and every SCK high and low phase lasts exactly HALF (4) clocks.
- R4: Bytes are sent MSB first. SO changes only after a falling SCK edge, and SI is sampled on the rising edge. In the normal layout, byte i is sent from address i and the received byte is written back to address i.
- R5: A transfer moves exactly length+1 bytes, from 1 up to the full 128.
- R6: In split mode, byte i is sent from address i and received into address 64+i. The byte count is limited to 64 whatever the length field holds, and addresses 0..63 are left unchanged.
- R7: In slave mode the channel shifts on an external SCK whose phases are each as short as 4 clocks.
- R8: SCK edges that arrive within 3 clocks after the chip select is asserted are ignored.
- R9: In slave mode SO is driven (so_oe=1) only while the chip select is low during a transfer; raising the chip select releases SO at once, and a transfer can resume after the chip select is asserted again.
- R10: done rises with the last rising SCK edge of the transfer, and busy then stays high for exactly 6 more clocks.
- R11: A start write clears done. Start, mode and length writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | 0 buffer, 1 control/status, 2 length |
| host_addr | input | 7 | Buffer byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| sck_i | input | 1 | External serial clock (slave) |
| sck_o | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | SCK output enable |
| cs_n_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | SO output enable |
| busy | output | 1 | Transfer or tail in progress |
| done | output | 1 | Last transfer completed |

## Verification
In master mode, a start written at one edge gives the first SCK fall HALF clocks later. Each later SCK edge follows HALF clocks after the one before. The bench checks SO one time unit after each rise, and it changes SI one time unit after each fall, so SI stays stable for a full phase. In slave mode, an external edge takes effect three clocks after it is driven: two synchroniser stages plus one register stage. The bench therefore samples SO on the fourth falling clock edge after it lowers SCK. done is checked right after the final SCK rise, and busy is then counted on six falling clock edges. Host reads are combinational, so they are sampled one time unit after the address is set on a falling edge.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } sio_state_e;

    localparam logic [1:0] SEL_BUF  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;

    localparam int CTRL_MASTER = 0;
    localparam int CTRL_SPLIT  = 1;
    localparam int CTRL_START  = 2;

endpackage

// File: rtl/sio_bufram.sv
module sio_bufram #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sio_sckgen.sv
module sio_sckgen #(
    parameter int HALF     = 4,
    parameter int MASK_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic run,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o,
    output logic si_o,
    output logic mask_o
);
    localparam int DIVW = $clog2(HALF + 1);
    localparam int MSKW = $clog2(MASK_CYC + 1);

    logic [DIVW-1:0] div_q;
    logic            sck_q;
    logic            sck_s0, sck_s1, sck_d;
    logic            cs_s0, cs_s1, cs_d;
    logic            si_s0, si_s1;
    logic [MSKW-1:0] msk_q;
    logic            m_tick, cs_fell, slave_ok;

    assign m_tick = run && (div_q == DIVW'(HALF - 1));

    // internal SCK: idles high, toggles every HALF clocks while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (!run) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (m_tick) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + DIVW'(1);
        end
    end

    // external pins: two-stage synchronisers plus an edge history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {sck_s0, sck_s1, sck_d} <= 3'b111;
            {cs_s0, cs_s1, cs_d}    <= 3'b111;
            {si_s0, si_s1}          <= 2'b00;
            msk_q                   <= '0;
        end else begin
            {sck_s0, sck_s1, sck_d} <= {sck_i, sck_s0, sck_s1};
            {cs_s0, cs_s1, cs_d}    <= {cs_n_i, cs_s0, cs_s1};
            {si_s0, si_s1}          <= {si_i, si_s0};
            if (cs_fell)
                msk_q <= MSKW'(MASK_CYC - 1);
            else if (msk_q != '0)
                msk_q <= msk_q - MSKW'(1);
        end
    end

    assign cs_fell  = cs_d & ~cs_s1;
    assign mask_o   = cs_fell | (msk_q != '0);
    assign slave_ok = ~cs_s1 & ~mask_o;

    assign sck_o  = sck_q;
    assign rise_o = master ? (m_tick & ~sck_q) : (slave_ok & sck_s1 & ~sck_d);
    assign fall_o = master ? (m_tick &  sck_q) : (slave_ok & ~sck_s1 & sck_d);
    assign si_o   = master ? si_i : si_s1;
endmodule

// File: rtl/sio_chan.sv
module sio_chan
    import sio_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int HALF     = 4,
    parameter int MASK_CYC = 3,
    parameter int BUSY_CYC = 6,
    localparam int AW      = $clog2(DEPTH),
    localparam int HALFD   = DEPTH / 2,
    localparam int TW      = $clog2(BUSY_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [1:0]    host_sel,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          cs_n_i,
    input  logic          si_i,
    output logic          so_o,
    output logic          so_oe,
    output logic          busy,
    output logic          done
);
    sio_state_e    state, nxt;
    logic          mode_master, mode_split, done_q, need_load;
    logic [AW-1:0] lenm1, bcnt, lastm1, eng_waddr, ram_waddr;
    logic [2:0]    bitcnt;
    logic [7:0]    shreg, rxsh, tx_byte, host_byte, ram_wdata;
    logic [TW-1:0] tcnt;
    logic          edge_rise, edge_fall, si_bit, mask_on, sck_run;
    logic          ctrl_wr, len_wr, buf_wr, start_req, byte_done, last_byte, ram_we;
    logic          unused_wdata;

    assign unused_wdata = ^host_wdata;

    assign ctrl_wr   = host_wr && (host_sel == SEL_CTRL);
    assign len_wr    = host_wr && (host_sel == SEL_LEN);
    assign buf_wr    = host_wr && (host_sel == SEL_BUF);
    assign start_req = ctrl_wr && host_wdata[CTRL_START] && (state == ST_IDLE);
    assign sck_run   = (state == ST_XFER);
    assign byte_done = sck_run && edge_rise && (bitcnt == 3'd7);
    assign last_byte = byte_done && (bcnt == lastm1);
    assign lastm1    = (mode_split && (lenm1 >= AW'(HALFD))) ? AW'(HALFD - 1) : lenm1;
    assign eng_waddr = mode_split ? (bcnt + AW'(HALFD)) : bcnt;

    // buffer write port: the engine wins over a same-cycle host write
    assign ram_we    = byte_done | buf_wr;
    assign ram_waddr = byte_done ? eng_waddr : host_addr;
    assign ram_wdata = byte_done ? {rxsh[6:0], si_bit} : host_wdata;

    sio_bufram #(.DEPTH(DEPTH), .DW(8)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (bcnt),
        .rdata_a (tx_byte),
        .raddr_b (host_addr),
        .rdata_b (host_byte)
    );

    sio_sckgen #(.HALF(HALF), .MASK_CYC(MASK_CYC)) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .master (mode_master),
        .run    (sck_run),
        .sck_i  (sck_i),
        .cs_n_i (cs_n_i),
        .si_i   (si_i),
        .sck_o  (sck_o),
        .rise_o (edge_rise),
        .fall_o (edge_fall),
        .si_o   (si_bit),
        .mask_o (mask_on)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_req) nxt = ST_XFER;
            ST_XFER: if (last_byte) nxt = ST_TAIL;
            ST_TAIL: if (tcnt == '0) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_master <= 1'b0;
            mode_split  <= 1'b0;
            lenm1       <= '0;
            bcnt        <= '0;
            bitcnt      <= '0;
            shreg       <= 8'hFF;
            rxsh        <= '0;
            need_load   <= 1'b0;
            tcnt        <= '0;
            done_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ctrl_wr) begin
                        mode_master <= host_wdata[CTRL_MASTER];
                        mode_split  <= host_wdata[CTRL_SPLIT];
                    end
                    if (len_wr) lenm1 <= host_wdata[AW-1:0];
                    if (start_req) begin
                        bcnt      <= '0;
                        bitcnt    <= '0;
                        need_load <= 1'b1;
                        done_q    <= 1'b0;
                    end
                end
                ST_XFER: begin
                    if (edge_fall) begin
                        if (need_load) begin
                            shreg     <= tx_byte;
                            need_load <= 1'b0;
                        end else begin
                            shreg <= {shreg[6:0], 1'b1};
                        end
                    end
                    if (edge_rise) begin
                        rxsh   <= {rxsh[6:0], si_bit};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            need_load <= 1'b1;
                            bcnt      <= bcnt + AW'(1);
                            if (bcnt == lastm1) begin
                                done_q <= 1'b1;
                                tcnt   <= TW'(BUSY_CYC - 1);
                            end
                        end
                    end
                end
                ST_TAIL: if (tcnt != '0) tcnt <= tcnt - TW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        done   = done_q;
        so_o   = shreg[7];
        sck_oe = mode_master;
        so_oe  = busy && (mode_master || !cs_n_i);
        unique case (host_sel)
            SEL_BUF:  host_rdata = host_byte;
            SEL_CTRL: host_rdata = {4'b0000, done_q, busy, mode_split, mode_master};
            SEL_LEN:  host_rdata = 8'(lenm1);
            default:  host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sio_chan_chk.sv
module sio_chan_chk
    import sio_pkg::*;
#(
    parameter int HALF     = 4,
    parameter int BUSY_CYC = 6,
    parameter int AW       = 7,
    parameter int HALFD    = 64
) (
    input logic          clk,
    input logic          rst_n,
    input sio_state_e    state,
    input logic          mode_master,
    input logic          mode_split,
    input logic          sck_o,
    input logic          so_o,
    input logic          edge_fall,
    input logic          mask_on,
    input logic [7:0]    shreg,
    input logic [2:0]    bitcnt,
    input logic [AW-1:0] bcnt,
    input logic          busy,
    input logic          done
);
    logic       sck_q;
    logic [7:0] ph, tc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            ph    <= 8'hFF;
            tc    <= '0;
        end else begin
            sck_q <= sck_o;
            if (sck_o != sck_q)  ph <= 8'd1;
            else if (ph != 8'hFF) ph <= ph + 8'd1;
            if (busy && done) tc <= tc + 8'd1;
            else              tc <= '0;
        end
    end

    // R3: generated SCK holds each level at least HALF clocks
    assert_sck_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && (sck_o != sck_q)) |-> (ph >= 8'(HALF)));

    // R4: SO moves only after a falling SCK edge
    assert_so_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_fall |=> $stable(so_o));

    // R6: split transfers stay inside the lower half
    assert_split_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && mode_split) |-> (bcnt < AW'(HALFD)));

    // R8: masked window after chip select leaves the shifter untouched
    assert_cs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && mask_on) |=> ($stable(shreg) && $stable(bitcnt)));

    // R10: busy tail lasts exactly BUSY_CYC clocks with done set
    assert_busy_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tc == 8'(BUSY_CYC)));

    // R11: done never coexists with shifting
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state != ST_XFER));
endmodule

bind sio_chan sio_chan_chk #(
    .HALF(HALF), .BUSY_CYC(BUSY_CYC), .AW(AW), .HALFD(HALFD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .mode_master (mode_master),
    .mode_split  (mode_split),
    .sck_o       (sck_o),
    .so_o        (so_o),
    .edge_fall   (edge_fall),
    .mask_on     (mask_on),
    .shreg       (shreg),
    .bitcnt      (bitcnt),
    .bcnt        (bcnt),
    .busy        (busy),
    .done        (done)
);

// File: tb/sim_sio_chan.sv
module sim_sio_chan;
    import sio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int HALF       = 4;
    localparam int PH         = 4;
    localparam int BUSY_CYC   = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [6:0] host_addr = 7'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sck_i = 1'b1, cs_n_i = 1'b1, si_i = 1'b0;
    logic       sck_o, sck_oe, so_o, so_oe, busy, done;

    int nchk = 0, nerr = 0, cyc = 0;
    int ph_min, ph_max;
    logic [7:0] model [DEPTH];
    logic [7:0] peer_tx [DEPTH];
    logic [7:0] cap [DEPTH];

    sio_chan u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .cs_n_i(cs_n_i),
        .si_i(si_i), .so_o(so_o), .so_oe(so_oe), .busy(busy), .done(done)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    function automatic int exp_count(input bit split, input int lenm1);
        if (split && lenm1 + 1 > DEPTH / 2) return DEPTH / 2;
        return lenm1 + 1;
    endfunction

    function automatic int exp_rx_addr(input bit split, input int i);
        return split ? i + DEPTH / 2 : i;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input int addr, input int data);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_addr = 7'(addr); host_wdata = 8'(data);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, input int addr, output logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b0; host_sel = sel; host_addr = 7'(addr);
        #1 d = host_rdata;
    endtask

    task automatic verify_buffer(input string req);
        int bad = 0, fa = 0, fe = 0;
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) begin
            host_read(SEL_BUF, i, d);
            if (d !== model[i]) begin
                if (bad == 0) begin fa = int'(d); fe = int'(model[i]); end
                bad++;
            end
        end
        check(bad == 0, req, fa, fe);
    endtask

    task automatic compare_cap(input int n, input bit split, input string req);
        int bad = 0, fa = 0, fe = 0;
        for (int i = 0; i < n; i++) begin
            if (cap[i] !== model[i]) begin
                if (bad == 0) begin fa = int'(cap[i]); fe = int'(model[i]); end
                bad++;
            end
        end
        check(bad == 0, req, fa, fe);
        for (int i = 0; i < n; i++) model[exp_rx_addr(split, i)] = peer_tx[i];
    endtask

    task automatic master_peer(input int n);
        int last = -1;
        ph_min = 1000; ph_max = 0;
        for (int b = 0; b < n; b++) begin
            for (int k = 7; k >= 0; k--) begin
                @(negedge sck_o); #1;
                if (last >= 0) begin
                    if (cyc - last < ph_min) ph_min = cyc - last;
                    if (cyc - last > ph_max) ph_max = cyc - last;
                end
                last = cyc;
                si_i = peer_tx[b][k];
                @(posedge sck_o); #1;
                if (cyc - last < ph_min) ph_min = cyc - last;
                if (cyc - last > ph_max) ph_max = cyc - last;
                last = cyc;
                cap[b][k] = so_o;
            end
        end
    endtask

    task automatic master_xfer(input int lenm1, input bit split, input bit poke);
        int n = exp_count(split, lenm1);
        int tail = 0;
        logic [7:0] d;
        for (int i = 0; i < n; i++) peer_tx[i] = 8'($urandom);
        host_write(SEL_LEN, 0, lenm1);
        host_write(SEL_CTRL, 0, 1 | (int'(split) << 1) | 4);
        host_read(SEL_CTRL, 0, d);
        check(d[3] == 1'b0, "R11 done cleared by start", int'(d[3]), 0);
        check(d[2] == 1'b1 && sck_oe == 1'b1, "R3 busy and sck_oe in master", int'(d[2]), 1);
        fork
            master_peer(n);
            if (poke) begin
                repeat (30) @(negedge clk);
                host_write(SEL_LEN, 0, 3);
                host_write(SEL_CTRL, 0, 7);
            end
        join
        check(done == 1'b1 && busy == 1'b1, "R10 done at last rise", int'(done), 1);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (!busy) break;
            tail++;
        end
        check(tail == BUSY_CYC, "R10 busy tail length", tail, BUSY_CYC);
        check(ph_min == HALF && ph_max == HALF, "R3 SCK phase width", ph_max, HALF);
        compare_cap(n, split, "R4 MSB-first transmit data");
        verify_buffer(split ? "R6 split buffer contents" : "R5 received bytes and length");
        if (poke) begin
            host_read(SEL_LEN, 0, d);
            check(int'(d) == lenm1, "R11 length write while busy ignored", int'(d), lenm1);
            host_read(SEL_CTRL, 0, d);
            check(d[2] == 1'b0 && d[1] == split, "R11 start while busy ignored", int'(d), 8 | 1);
        end
    endtask

    task automatic slave_xfer(input int n, input bit glitch, input bit gap);
        int bad_oe = 0;
        for (int i = 0; i < n; i++) peer_tx[i] = 8'($urandom);
        host_write(SEL_LEN, 0, n - 1);
        host_write(SEL_CTRL, 0, 4);
        @(negedge clk);
        cs_n_i = 1'b0;
        if (glitch) begin
            sck_i = 1'b0;
            @(negedge clk);
            sck_i = 1'b1;
        end
        repeat (6) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            if (gap && b == 1) begin
                cs_n_i = 1'b1;
                @(negedge clk);
                check(so_oe == 1'b0, "R9 SO released on deselect", int'(so_oe), 0);
                repeat (4) @(negedge clk);
                cs_n_i = 1'b0;
                repeat (6) @(negedge clk);
            end
            for (int k = 7; k >= 0; k--) begin
                sck_i = 1'b0; si_i = peer_tx[b][k];
                repeat (PH) @(negedge clk);
                cap[b][k] = so_o;
                if (!so_oe) bad_oe++;
                sck_i = 1'b1;
                repeat (PH) @(negedge clk);
            end
        end
        for (int t = 0; t < 40 && busy; t++) @(negedge clk);
        cs_n_i = 1'b1;
        check(bad_oe == 0, "R9 SO driven while selected", bad_oe, 0);
        check(done == 1'b1 && busy == 1'b0, "R7 slave transfer completes", int'(done), 1);
        compare_cap(n, 1'b0, glitch ? "R8 early edges masked" : "R7 slave transmit data");
        verify_buffer("R7 slave received bytes");
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd7411));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R1 reset busy/done", int'({busy, done}), 0);
        check(so_oe == 0 && sck_oe == 0, "R1 reset drivers off", int'({so_oe, sck_oe}), 0);
        check(sck_o == 1 && so_o == 1, "R1 reset line levels", int'({sck_o, so_o}), 3);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 host access
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 8'($urandom);
            host_write(SEL_BUF, i, int'(model[i]));
        end
        verify_buffer("R2 buffer write/read");
        host_write(SEL_LEN, 0, 9);
        host_read(SEL_LEN, 0, d);
        check(d == 8'd9, "R2 length readback", int'(d), 9);
        host_write(SEL_CTRL, 0, 3);
        host_read(SEL_CTRL, 0, d);
        check(d == 8'd3, "R2 control readback", int'(d), 3);

        // master transfers
        master_xfer(0, 1'b0, 1'b0);
        master_xfer(int'($urandom_range(2, 20)), 1'b0, 1'b0);
        master_xfer(int'($urandom_range(21, 60)), 1'b0, 1'b0);
        master_xfer(DEPTH - 1, 1'b0, 1'b1);
        master_xfer(99, 1'b1, 1'b0);
        master_xfer(int'($urandom_range(3, 30)), 1'b1, 1'b0);

        // slave transfers
        slave_xfer(3, 1'b1, 1'b1);
        slave_xfer(2, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule